// File: doc/BRIEF.md
# Write-Protection Register Controller

This block owns the one-byte protection register of a serial memory device. The bus front end forwards register write bytes to it and presents each array write target address. The block returns two things. The first is a verdict on whether an array write to that address may go ahead. The second is the current state of the array write-enable latch. It also presents the register as a readable byte. The bus protocol and the storage array itself sit outside this block.

The register holds two enable latches and two protection fields. The array latch must be set before anything can be written. A second latch, the register latch, must then be set before the lock fields may change. The new lock fields are loaded by a final write that clears the register latch again. The lock field selects how much of the top of the array is frozen: nothing, the top quarter, the top half, or everything. A hardware-protect bit, combined with the external protect pin, freezes the register itself. Unlocked parts of the array stay writable while the register is frozen.

Top module: `wpr_ctrl`

## Requirements
- R1: While the synchronous active-low reset is asserted, the array latch, the register latch, the lock field and the hardware-protect bit are all cleared, so the readback equals only the busy bit.
- R2: Writing 02h while the register latch is 0 sets the array latch.
- R3: Writing 06h sets the register latch only when the array latch is 1 and hardware protection is off. Otherwise the register is unchanged. The register latch is never 1 while the array latch is 0.
- R4: When both latches are 1 and hardware protection is off, a write whose bits 6:5 are 00 and bits 2:0 are 010 loads bit 7 into the hardware-protect bit and bits 4:3 into the lock field. It also clears the register latch and leaves the array latch at 1.
- R5: While the register latch is 1, a write with bit 2 set (other than 00h) leaves the whole register unchanged.
- R6: Hardware protection is on only when the hardware-protect bit is 1 and the protect pin is high. While it is on, the register latch cannot be set, and the lock field and hardware-protect bit cannot change.
- R7: Writing 00h clears both latches at any time and leaves the lock field and hardware-protect bit unchanged.
- R8: Any other byte (while the register latch is 0, anything but 00h, 02h, 06h) leaves the register unchanged.
- R9: With a 14-bit address, lock field 00 locks nothing, 01 locks 3000h–3FFFh, 10 locks 2000h–3FFFh, and 11 locks the whole array.
- R10: The array write verdict is 1 exactly when the array latch is 1 and the address is outside the locked range. The protect pin has no effect on it. The array write-enable output equals the array latch.
- R11: The readback byte holds the hardware-protect bit at bit 7, zeros at bits 6:5, the lock field at bits 4:3, the register latch at bit 2, the array latch at bit 1, and the busy input at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| reg_wr_en | input | 1 | One-cycle strobe for a register write |
| reg_wr_data | input | 8 | Byte written to the register |
| wp_pin | input | 1 | External hardware-protect pin, active high |
| busy | input | 1 | Internal write-cycle busy flag, shown at readback bit 0 |
| arr_addr | input | ADDR_W (14) | Target address of the pending array write |
| arr_permit | output | 1 | 1 when an array write to arr_addr is allowed |
| arr_wr_enable | output | 1 | State of the array write-enable latch |
| reg_rdata | output | 8 | Register readback byte |

## Verification
The assertions assume that reg_wr_data, wp_pin and arr_addr are stable around each rising edge. They also assume that a register write is a single-cycle strobe judged against the register state of that same edge. The bench meets both assumptions by changing every input only at the falling edge. The unlock sequences are driven with the protect pin both high and low, including the pin rising while the register latch is already set. A random phase then mixes legal and illegal bytes with random pin, busy and address values.

// File: rtl/wpr_pkg.sv
// Shared definitions for the write-protection register controller.
// Assumes an 8-bit register; bit positions are fixed by the readback layout.
package wpr_pkg;
    localparam int REG_W     = 8;
    localparam int BIT_WPEN  = 7;
    localparam int BIT_BLHI  = 4;
    localparam int BIT_BLLO  = 3;
    localparam int BIT_RWEL  = 2;
    localparam int BIT_WEL   = 1;
    localparam int BIT_BUSY  = 0;

    localparam logic [REG_W-1:0] BYTE_CLEAR   = 8'h00;
    localparam logic [REG_W-1:0] BYTE_SET_WEL = 8'h02;
    localparam logic [REG_W-1:0] BYTE_SET_RW  = 8'h06;

    // Decoded effect of one register write.
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_CLEAR,
        CMD_SET_WEL,
        CMD_SET_RWEL,
        CMD_COMMIT
    } wpr_cmd_t;

    // True when a byte has the commit shape: bits 6:5 zero, bits 2:0 = 010.
    function automatic logic is_commit_shape(input logic [REG_W-1:0] d);
        return (d[6:5] == 2'b00) && (d[2:0] == 3'b010);
    endfunction
endpackage

// File: rtl/wpr_cmd_decode.sv
// Classifies a register write byte against the current latch state.
// Assumes the latch and protect inputs are the registered values of this cycle.
module wpr_cmd_decode
    import wpr_pkg::*;
(
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             wel,
    input  logic             rwel,
    input  logic             hw_lock,
    output wpr_cmd_t         cmd
);
    // Priority: clear, then commit or ignore while unlocked, then latch sets.
    always_comb begin
        cmd = CMD_NONE;
        if (wr_en) begin
            if (wr_data == BYTE_CLEAR) begin
                cmd = CMD_CLEAR;
            end else if (rwel) begin
                if (is_commit_shape(wr_data) && wel && !hw_lock)
                    cmd = CMD_COMMIT;
            end else if (wr_data == BYTE_SET_WEL) begin
                cmd = CMD_SET_WEL;
            end else if (wr_data == BYTE_SET_RW && wel && !hw_lock) begin
                cmd = CMD_SET_RWEL;
            end
        end
    end
endmodule

// File: rtl/wpr_state.sv
// Holds the latches, lock field and hardware-protect bit and applies commands.
// Assumes a synchronous active-low reset that stands for power-on.
module wpr_state
    import wpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  wpr_cmd_t         cmd,
    input  logic [REG_W-1:0] wr_data,
    input  logic             wr_en,
    input  logic             hw_lock,
    output logic             wel_q,
    output logic             rwel_q,
    output logic [1:0]       bl_q,
    output logic             wpen_q
);
    // Register update per decoded command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q  <= 1'b0;
            rwel_q <= 1'b0;
            bl_q   <= 2'b00;
            wpen_q <= 1'b0;
        end else begin
            unique case (cmd)
                CMD_CLEAR: begin
                    wel_q  <= 1'b0;
                    rwel_q <= 1'b0;
                end
                CMD_SET_WEL:  wel_q  <= 1'b1;
                CMD_SET_RWEL: rwel_q <= 1'b1;
                CMD_COMMIT: begin
                    wpen_q <= wr_data[BIT_WPEN];
                    bl_q   <= wr_data[BIT_BLHI:BIT_BLLO];
                    rwel_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assert_rwel_implies_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rwel_q |-> wel_q);

    assert_rwel_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(rwel_q) |-> $past(wel_q) && !$past(hw_lock));

    assert_bl_needs_rwel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (!$stable(bl_q) || !$stable(wpen_q)) |-> $past(rwel_q));

    assert_hw_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(hw_lock) |-> $stable(bl_q) && $stable(wpen_q) && !$rose(rwel_q));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en) && ($past(wr_data) == 8'h00) |-> !wel_q && !rwel_q);
endmodule

// File: rtl/wpr_lock_decode.sv
// Decides whether an array address lies in the block-locked top region.
// Assumes ADDR_W >= 2; region sizes are quarter, half and whole array.
module wpr_lock_decode #(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bl,
    output logic              locked
);
    localparam int TOP = ADDR_W - 1;

    // Range compare on the top address bits selected by the lock field.
    always_comb begin
        unique case (bl)
            2'b00: locked = 1'b0;
            2'b01: locked = addr[TOP] & addr[TOP-1];
            2'b10: locked = addr[TOP];
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/wpr_ctrl.sv
// Write-protection register controller top: decode, state, lock range, readback.
// Assumes register writes are single-cycle strobes and arr_addr is held stable
// while arr_permit is being used.
module wpr_ctrl
    import wpr_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wr_data,
    input  logic              wp_pin,
    input  logic              busy,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic              arr_permit,
    output logic              arr_wr_enable,
    output logic [7:0]        reg_rdata
);
    logic       wel_q, rwel_q, wpen_q, hw_lock, locked;
    logic [1:0] bl_q;
    wpr_cmd_t   cmd;

    // Hardware protection needs both the stored bit and the pin.
    always_comb hw_lock = wpen_q & wp_pin;

    wpr_cmd_decode u_dec (
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .wel     (wel_q),
        .rwel    (rwel_q),
        .hw_lock (hw_lock),
        .cmd     (cmd)
    );

    wpr_state u_st (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .wr_data (reg_wr_data),
        .wr_en   (reg_wr_en),
        .hw_lock (hw_lock),
        .wel_q   (wel_q),
        .rwel_q  (rwel_q),
        .bl_q    (bl_q),
        .wpen_q  (wpen_q)
    );

    wpr_lock_decode #(.ADDR_W(ADDR_W)) u_lock (
        .addr   (arr_addr),
        .bl     (bl_q),
        .locked (locked)
    );

    // Array verdict and write-enable result.
    always_comb begin
        arr_permit    = wel_q & ~locked;
        arr_wr_enable = wel_q;
    end

    // Readback byte assembly.
    always_comb begin
        reg_rdata           = '0;
        reg_rdata[BIT_WPEN] = wpen_q;
        reg_rdata[BIT_BLHI] = bl_q[1];
        reg_rdata[BIT_BLLO] = bl_q[0];
        reg_rdata[BIT_RWEL] = rwel_q;
        reg_rdata[BIT_WEL]  = wel_q;
        reg_rdata[BIT_BUSY] = busy;
    end

    assert_unlocked_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_enable && (reg_rdata[4:3] == 2'b00) |-> arr_permit);

    assert_full_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[4:3] == 2'b11) |-> !arr_permit);

    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6:5] == 2'b00);
endmodule

// File: tb/sim_wpr_ctrl.sv
module sim_wpr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_data = 8'h00;
    logic        wp_pin = 1'b0;
    logic        busy = 1'b0;
    logic [13:0] arr_addr = 14'h0;
    logic        arr_permit, arr_wr_enable;
    logic [7:0]  reg_rdata;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state.
    bit m_wel, m_rwel, m_wpen;
    int m_bl;

    always #10 clk = ~clk;

    wpr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .wp_pin(wp_pin), .busy(busy), .arr_addr(arr_addr), .arr_permit(arr_permit),
        .arr_wr_enable(arr_wr_enable), .reg_rdata(reg_rdata)
    );

    function automatic bit ref_locked(int a, int bl);
        if (bl == 3) return 1;
        if (bl == 2) return a >= 'h2000;
        if (bl == 1) return a >= 'h3000;
        return 0;
    endfunction

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        bit prot;
        prot = m_wpen && wp_pin;
        if (!rst_n) begin
            m_wel = 0; m_rwel = 0; m_wpen = 0; m_bl = 0;
        end else if (reg_wr_en) begin
            if (reg_wr_data == 8'h00) begin
                m_wel = 0; m_rwel = 0;
            end else if (m_rwel) begin
                if (!prot && reg_wr_data[2:0] == 3'b010 && reg_wr_data[6:5] == 2'b00) begin
                    m_wpen = reg_wr_data[7];
                    m_bl = (reg_wr_data >> 3) & 3;
                    m_rwel = 0;
                end
            end else if (reg_wr_data == 8'h02) begin
                m_wel = 1;
            end else if (reg_wr_data == 8'h06 && m_wel && !prot) begin
                m_rwel = 1;
            end
        end
    end

    // Per-clock comparison, 5 ns after the edge.
    always @(posedge clk) begin
        logic [7:0] exp_rd;
        bit exp_pm;
        #5;
        exp_rd = {m_wpen, 2'b00, 2'(m_bl), m_rwel, m_wel, busy};
        exp_pm = m_wel && !ref_locked(int'(arr_addr), m_bl);
        checks++;
        if (reg_rdata !== exp_rd) begin
            errors++;
            $display("FAIL R11 clock readback: got %02h expected %02h", reg_rdata, exp_rd);
        end
        checks++;
        if (arr_permit !== exp_pm || arr_wr_enable !== m_wel) begin
            errors++;
            $display("FAIL R10 clock permit/enable: got %0b/%0b expected %0b/%0b",
                     arr_permit, arr_wr_enable, exp_pm, m_wel);
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wr_data = 8'h00;
        #1;
    endtask

    task automatic permit_at(input logic [13:0] a, input logic exp, input string tag);
        arr_addr = a;
        #1;
        chk(tag, {7'd0, arr_permit}, {7'd0, exp});
    endtask

    task automatic unlock();
        wr(8'h06);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset readback", reg_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk); #1;
        permit_at(14'h0000, 1'b0, "R10 no permit with WEL=0");
        wr(8'h06);
        chk("R3 RWEL refused without WEL", reg_rdata, 8'h00);
        wr(8'h02);
        chk("R2 WEL set", reg_rdata, 8'h02);
        permit_at(14'h3FFF, 1'b1, "R10 permit when unlocked");
        wr(8'h12);
        chk("R8 commit shape ignored while RWEL=0", reg_rdata, 8'h02);
        wr(8'h55);
        chk("R8 stray byte ignored", reg_rdata, 8'h02);
        unlock();
        chk("R3 RWEL set", reg_rdata, 8'h06);
        wr(8'h0E);
        chk("R5 bit2 write ignored", reg_rdata, 8'h06);
        wr(8'h0A);
        chk("R4 commit BL=01", reg_rdata, 8'h0A);
        permit_at(14'h2FFF, 1'b1, "R9 BL01 below 3000h");
        permit_at(14'h3000, 1'b0, "R9 BL01 at 3000h");
        unlock();
        wr(8'h12);
        chk("R4 commit BL=10", reg_rdata, 8'h12);
        permit_at(14'h1FFF, 1'b1, "R9 BL10 below 2000h");
        permit_at(14'h2000, 1'b0, "R9 BL10 at 2000h");
        unlock();
        wr(8'h9A);
        chk("R4 commit BL=11 WPEN=1", reg_rdata, 8'h9A);
        permit_at(14'h0000, 1'b0, "R9 BL11 locks 0000h");
        wp_pin = 1'b1;
        wr(8'h06);
        chk("R6 RWEL blocked by hw protect", reg_rdata, 8'h9A);
        wp_pin = 1'b0;
        wr(8'h06);
        chk("R6 RWEL allowed with pin low", reg_rdata, 8'h9E);
        wp_pin = 1'b1;
        wr(8'h02);
        chk("R6 commit blocked by hw protect", reg_rdata, 8'h9E);
        wp_pin = 1'b0;
        wr(8'h82);
        chk("R4 commit WPEN=1 BL=00", reg_rdata, 8'h82);
        wp_pin = 1'b1;
        permit_at(14'h3FFF, 1'b1, "R10 unlocked region open under hw protect");
        wp_pin = 1'b0;
        unlock();
        wr(8'h00);
        chk("R7 clear both latches", reg_rdata, 8'h80);
        permit_at(14'h0100, 1'b0, "R10 no permit after clear");
        busy = 1'b1;
        #1;
        chk("R11 busy bit", reg_rdata, 8'h81);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R1 reset clears all", reg_rdata, 8'h01);
        rst_n = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            wp_pin   = 1'($urandom_range(0, 1));
            busy     = 1'($urandom_range(0, 1));
            arr_addr = 14'($urandom);
            reg_wr_en = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 9))
                0: reg_wr_data = 8'h00;
                1, 2: reg_wr_data = 8'h02;
                3, 4: reg_wr_data = 8'h06;
                5: reg_wr_data = 8'h0E;
                6: reg_wr_data = {1'($urandom_range(0, 1)), 2'b00, 2'($urandom), 3'b010};
                7: reg_wr_data = 8'h9A;
                default: reg_wr_data = 8'($urandom);
            endcase
        end
        @(negedge clk);
        reg_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule